// File: doc/BRIEF.md
# Half-Period Interrupt Timer

This block is a free-running timer peripheral with a classic Wishbone slave port. Inside it a 15-bit counter steps up by one on every clock. Whenever the counter's most significant bit (bit 14) becomes set, a pending flag is raised and drives a level interrupt line. That line stays high until software reads the status register.

The status read returns the pending flag in bit 0. The read also clears the flag and clears counter bit 14. The low 14 bits keep counting, so the next interrupt comes only after the counter climbs back into its upper half. The port has no address decode, since the status register is the only one. Every access is acknowledged in a single cycle. Writes are accepted and do nothing.

Top module: `msb_irq_timer`

## Requirements
- R1: During synchronous reset (active-high `rst`) the counter is zeroed, and `irq`, `wb_ack` and `wb_dat_r` are all driven low.
- R2: The counter advances by one on every clock while out of reset. With no reads, `irq` first goes high on exactly the 16384th rising edge after reset is released, which is the edge where counter bit 14 first becomes set.
- R3: `irq` is high whenever counter bit 14 is set. Once raised, `irq` stays high until a clearing read, even when the counter wraps from 0x7FFF to zero.
- R4: A read returns the pending flag in bit 0 of `wb_dat_r` and zeros in bits 31:1. The value is the flag as it stood when the access was accepted, before that access clears anything.
- R5: An acknowledged read (`wb_we` low) clears the pending flag and counter bit 14. The low 14 bits keep counting, and the next `irq` rises when the counter reaches 0x4000 again.
- R6: `wb_ack` is high for one cycle, on the cycle after the request is accepted. A request is accepted when `wb_cyc` and `wb_stb` are both high and `wb_ack` is low. `wb_ack` is never high on two consecutive cycles, so a held request is acknowledged every other cycle.
- R7: A write (`wb_we` high) is acknowledged and changes neither the counter nor `irq`.
- R8: Suppose a clearing read is accepted on the same edge at which counter bit 14 would become set. Then the clear wins: `irq` stays low, the counter goes to zero, and the next `irq` comes 16384 edges later.
- R9: `wb_cyc` without `wb_stb`, or `wb_stb` without `wb_cyc`, produces no acknowledge and has no side effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wb_cyc | input | 1 | Bus cycle valid |
| wb_stb | input | 1 | Strobe for this slave |
| wb_we | input | 1 | 1 = write, 0 = read |
| wb_dat_r | output | 32 | Read data: pending flag in bit 0 during an acknowledge, zero otherwise |
| wb_ack | output | 1 | One-cycle acknowledge |
| irq | output | 1 | Level interrupt, high while the pending flag is set |

## Verification
The embedded assertions watch properties that must hold on every cycle:
- the single-cycle acknowledge that follows a request;
- the counter stepping by one;
- counter bit 14 being clear after a clearing read;
- `irq` being high whenever bit 14 is set and holding until a read;
- the zero upper bits of the read data.

Other behaviours depend on long stretches of time or on a deliberately placed access, so only the bench scenarios show them. These are the exact edge on which the first interrupt appears, the pending flag surviving a counter wrap, writes having no effect, and the clear winning when a read lands on the edge where bit 14 would be set. The bench runs a reference model of the counter and flag alongside the design, and it compares `irq`, `wb_ack` and the read data against that model.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    parameter int TMR_DATA_W = 32;
    parameter int TMR_CNT_W  = 15;

    typedef struct packed {
        logic cyc;
        logic stb;
        logic we;
    } tmr_req_t;

    function automatic logic [TMR_DATA_W-1:0] status_word(input logic pending);
        logic [TMR_DATA_W-1:0] w;
        w    = '0;
        w[0] = pending;
        return w;
    endfunction

endpackage

// File: rtl/tmr_bus_port.sv
module tmr_bus_port
    import tmr_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  tmr_req_t              req,
    input  logic                  pending,
    output logic                  rd_clear,
    output logic [TMR_DATA_W-1:0] dat_r,
    output logic                  ack
);

    logic accept;

    always_comb begin
        accept   = req.cyc & req.stb & ~ack;
        rd_clear = accept & ~req.we;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ack   <= 1'b0;
            dat_r <= '0;
        end else begin
            ack   <= accept;
            dat_r <= accept ? status_word(pending) : '0;
        end
    end

    p_ack_single_r6: assert property (@(posedge clk) disable iff (rst)
        ack |=> !ack);
    p_ack_after_req_r6: assert property (@(posedge clk) disable iff (rst)
        $past(!rst) && ack |-> $past(req.cyc && req.stb));
    p_no_ack_idle_r9: assert property (@(posedge clk) disable iff (rst)
        !(req.cyc && req.stb) |=> !ack);
    p_rdata_upper_zero_r4: assert property (@(posedge clk) disable iff (rst)
        dat_r[TMR_DATA_W-1:1] == '0);

endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
    parameter int CNT_W = 15
) (
    input  logic clk,
    input  logic rst,
    input  logic clr_msb,
    output logic msb_now,
    output logic msb_next
);

    localparam int MSB = CNT_W - 1;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] cnt_nxt;

    always_comb begin
        cnt_nxt = cnt + 1'b1;
        if (clr_msb) begin
            cnt_nxt[MSB] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else begin
            cnt <= cnt_nxt;
        end
    end

    assign msb_now  = cnt[MSB];
    assign msb_next = cnt_nxt[MSB];

    p_low_bits_step_r2: assert property (@(posedge clk) disable iff (rst)
        $past(!rst) |-> cnt[MSB-1:0] == $past(cnt[MSB-1:0]) + 1'b1);
    p_msb_step_r2: assert property (@(posedge clk) disable iff (rst)
        $past(!rst) && !$past(clr_msb) |-> cnt == $past(cnt) + 1'b1);
    p_clear_msb_r5: assert property (@(posedge clk) disable iff (rst)
        clr_msb |=> !cnt[MSB]);

endmodule

// File: rtl/tmr_irq_flag.sv
module tmr_irq_flag (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic msb_next,
    output logic pending
);

    always_ff @(posedge clk) begin
        if (rst) begin
            pending <= 1'b0;
        end else if (clr) begin
            pending <= 1'b0;
        end else if (msb_next) begin
            pending <= 1'b1;
        end
    end

    p_hold_until_read_r3: assert property (@(posedge clk) disable iff (rst)
        pending && !clr |=> pending);
    p_read_clears_r5: assert property (@(posedge clk) disable iff (rst)
        clr |=> !pending);

endmodule

// File: rtl/msb_irq_timer.sv
module msb_irq_timer
    import tmr_pkg::*;
#(
    parameter int CNT_W = TMR_CNT_W
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wb_cyc,
    input  logic                  wb_stb,
    input  logic                  wb_we,
    output logic [TMR_DATA_W-1:0] wb_dat_r,
    output logic                  wb_ack,
    output logic                  irq
);

    tmr_req_t req;
    logic     rd_clear;
    logic     msb_now;
    logic     msb_next;
    logic     pending;

    assign req.cyc = wb_cyc;
    assign req.stb = wb_stb;
    assign req.we  = wb_we;

    tmr_bus_port u_port (
        .clk      (clk),
        .rst      (rst),
        .req      (req),
        .pending  (pending),
        .rd_clear (rd_clear),
        .dat_r    (wb_dat_r),
        .ack      (wb_ack)
    );

    tmr_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .clr_msb  (rd_clear),
        .msb_now  (msb_now),
        .msb_next (msb_next)
    );

    tmr_irq_flag u_flag (
        .clk      (clk),
        .rst      (rst),
        .clr      (rd_clear),
        .msb_next (msb_next),
        .pending  (pending)
    );

    assign irq = pending;

    p_irq_on_msb_r3: assert property (@(posedge clk) disable iff (rst)
        msb_now |-> irq);
    p_write_keeps_irq_r7: assert property (@(posedge clk) disable iff (rst)
        irq && wb_cyc && wb_stb && wb_we |=> irq);
    p_clear_wins_r8: assert property (@(posedge clk) disable iff (rst)
        rd_clear |=> !irq && !msb_now);

endmodule

// File: tb/test_msb_irq_timer.sv
module test_msb_irq_timer;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wb_cyc = 1'b0;
    logic        wb_stb = 1'b0;
    logic        wb_we = 1'b0;
    logic [31:0] wb_dat_r;
    logic        wb_ack;
    logic        irq;

    always #2 clk = ~clk;

    msb_irq_timer i_msb_irq_timer (
        .clk      (clk),
        .rst      (rst),
        .wb_cyc   (wb_cyc),
        .wb_stb   (wb_stb),
        .wb_we    (wb_we),
        .wb_dat_r (wb_dat_r),
        .wb_ack   (wb_ack),
        .irq      (irq)
    );

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // reference model built from the requirements
    logic [14:0] m_cnt;
    logic        m_flag;
    logic        m_ack;
    logic [31:0] exp_q[$];

    always @(posedge clk) begin
        logic [14:0] n;
        logic        acc;
        logic        rd;
        if (rst) begin
            m_cnt  <= '0;
            m_flag <= 1'b0;
            m_ack  <= 1'b0;
        end else begin
            acc = wb_cyc && wb_stb && !m_ack;
            rd  = acc && !wb_we;
            n = m_cnt + 15'd1;
            if (rd) n[14] = 1'b0;
            if (acc) exp_q.push_back({31'd0, m_flag});
            m_cnt  <= n;
            m_flag <= rd ? 1'b0 : (m_flag | n[14]);
            m_ack  <= acc;
        end
    end

    // monitor: compare against the model away from the active edge
    always @(negedge clk) begin
        if (!rst && !done) begin
            if (irq !== m_flag) check(1'b0, "R3 irq vs model", int'(irq), int'(m_flag));
            if (wb_ack !== m_ack) check(1'b0, "R6 ack vs model", int'(wb_ack), int'(m_ack));
            if (wb_ack) begin
                logic [31:0] e;
                if (exp_q.size() == 0) begin
                    check(1'b0, "R6 ack without request", 1, 0);
                end else begin
                    e = exp_q.pop_front();
                    check(wb_dat_r === e, "R4 read data", int'(wb_dat_r), int'(e));
                end
            end else if (wb_dat_r !== 32'd0) begin
                check(1'b0, "R4 data zero outside ack", int'(wb_dat_r), 0);
            end
        end
    end

    task automatic bus_xfer(input bit we, output logic [31:0] rd);
        @(negedge clk);
        wb_cyc = 1'b1;
        wb_stb = 1'b1;
        wb_we  = we;
        do @(negedge clk); while (!wb_ack);
        rd = wb_dat_r;
        wb_cyc = 1'b0;
        wb_stb = 1'b0;
        wb_we  = 1'b0;
    endtask

    task automatic edges_to_irq(output int n);
        n = 0;
        while (!irq && n < 40000) begin
            @(negedge clk);
            n++;
        end
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        int          n;
        int          acks;
        bit          prev;
        bit          dbl;

        repeat (3) @(negedge clk);
        // R1 reset state
        check(irq === 1'b0, "R1 irq in reset", int'(irq), 0);
        check(wb_ack === 1'b0, "R1 ack in reset", int'(wb_ack), 0);
        check(wb_dat_r === 32'd0, "R1 data in reset", int'(wb_dat_r), 0);
        rst = 1'b0;

        // R2 first interrupt on the 16384th edge
        edges_to_irq(n);
        check(n == 16384, "R2 edges to first irq", n, 16384);

        // R7 write does not clear
        bus_xfer(1'b1, rd);
        @(negedge clk);
        check(irq === 1'b1, "R7 irq after write", int'(irq), 1);

        // R4/R5 read returns flag and clears it
        bus_xfer(1'b0, rd);
        check(rd === 32'd1, "R4 read pending", int'(rd), 1);
        @(negedge clk);
        check(irq === 1'b0, "R5 irq after read", int'(irq), 0);
        bus_xfer(1'b0, rd);
        check(rd === 32'd0, "R4 read idle flag", int'(rd), 0);

        // R5 next interrupt when counter reaches 0x4000 again
        n = 16384 - int'(m_cnt);
        begin
            int k;
            edges_to_irq(k);
            check(k == n, "R5 re-arm distance", k, n);
        end

        // R9 lone cyc or lone stb
        wb_cyc = 1'b1;
        repeat (3) begin
            @(negedge clk);
            check(wb_ack === 1'b0, "R9 cyc only no ack", int'(wb_ack), 0);
        end
        wb_cyc = 1'b0;
        wb_stb = 1'b1;
        repeat (3) begin
            @(negedge clk);
            check(wb_ack === 1'b0, "R9 stb only no ack", int'(wb_ack), 0);
        end
        wb_stb = 1'b0;
        check(irq === 1'b1, "R9 irq untouched", int'(irq), 1);

        // R6 held read request: ack every other cycle
        wb_cyc = 1'b1;
        wb_stb = 1'b1;
        acks = 0;
        prev = 1'b0;
        dbl  = 1'b0;
        repeat (6) begin
            @(negedge clk);
            if (wb_ack) acks++;
            if (wb_ack && prev) dbl = 1'b1;
            prev = wb_ack;
        end
        wb_cyc = 1'b0;
        wb_stb = 1'b0;
        check(acks == 3, "R6 acks for held request", acks, 3);
        check(!dbl, "R6 no back-to-back ack", int'(dbl), 0);
        @(negedge clk);

        // R8 read accepted on the edge bit 14 would be set
        bus_xfer(1'b0, rd);
        while (m_cnt != 15'h3FFF) @(negedge clk);
        wb_cyc = 1'b1;
        wb_stb = 1'b1;
        @(negedge clk);
        check(wb_ack === 1'b1, "R8 ack on clash", int'(wb_ack), 1);
        check(wb_dat_r === 32'd0, "R8 data on clash", int'(wb_dat_r), 0);
        wb_cyc = 1'b0;
        wb_stb = 1'b0;
        check(irq === 1'b0, "R8 clear wins", int'(irq), 0);
        edges_to_irq(n);
        check(n == 16384, "R8 next irq distance", n, 16384);

        // R3 pending survives counter wrap
        repeat (20000) @(negedge clk);
        check(irq === 1'b1, "R3 irq after wrap", int'(irq), 1);
        bus_xfer(1'b0, rd);
        check(rd === 32'd1, "R3 read after wrap", int'(rd), 1);

        repeat (2) @(negedge clk);
        check(exp_q.size() == 0, "R6 scoreboard drained", exp_q.size(), 0);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule